// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO Controller

A single-clock FIFO with a parameterised depth and a 36-bit word. After every reset it settles into one of two read timings, chosen by a mode input. In standard timing the head word reaches the output only when a read is requested, and the two status outputs act as "not empty" and "not full". In fall-through timing the oldest word is moved to the output register without any request, and the same outputs act as "output valid" and "space available".

Two active-low threshold flags compare the fill level with offset inputs. One warns when few words remain and the other warns when little space remains. Reset is asserted asynchronously and released through a two-stage synchroniser. Writes are accepted only after a short start-up delay, and the mode is captured during that delay.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode input is captured on the first rising edge after the synchronised reset release, which is the third rising edge after `rst_n` goes high. A value of 1 selects standard timing and 0 selects fall-through timing.
- R2: The captured mode stays fixed until the next reset, whatever the mode input does afterwards.
- R3: In standard timing, `data_ok` is high exactly when at least one word is stored, and `rd_data` changes only on the edge that accepts a read. It then shows the oldest word. No word, including the first, reaches `rd_data` without an accepted read.
- R4: In fall-through timing, a word written while the output holds no valid word appears on `rd_data` with `data_ok` high, two rising edges after its write, with no read. Each read while `data_ok` is high consumes the shown word, and the next word follows on the same edge if one is stored.
- R5: While `rst_n` is low, and until the synchronised release, the FIFO is emptied, `space_ok` and `data_ok` are 0, `ae_n` is 0 and `af_n` is 1. `rst_n` may fall at any time.
- R6: `space_ok` first goes high on the fourth rising edge after `rst_n` goes high, which is two edges after the synchronised release. No write is accepted before then.
- R7: After the synchronised release, `ae_n` is 0 exactly when the number of stored words, counting the output word in fall-through timing, is at most `ae_off`.
- R8: After the synchronised release, `af_n` is 0 exactly when DEPTH minus the number of stored words is at most `af_off`.
- R9: A write while `space_ok` is low and a read while `data_ok` is low are ignored. The stored contents and `rd_data` are left unchanged.
- R10: Up to DEPTH words are held in both modes. `space_ok` is low when DEPTH words are stored, and words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| mode_sel | input | 1 | Timing choice captured after reset: 1 standard, 0 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Output word register |
| ae_off | input | CW | Almost-empty threshold |
| af_off | input | CW | Almost-full threshold |
| space_ok | output | 1 | Not full (standard) or space available (fall-through); low during start-up |
| data_ok | output | 1 | Not empty (standard) or output valid (fall-through) |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The hardest situation to reach is fall-through timing with a full store, where the output register is itself one of the DEPTH words. A refill must land on the same edge as a consumed read while a write is refused. The bench brings this about by streaming writes with the read request withheld until `space_ok` drops. It then keeps writing while it reads, so that the refused-write and refill cases line up on single edges. A behavioural queue model, updated on every edge, predicts every output. Separate directed steps count the edges from reset release to the mode capture and to the first `space_ok`.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 36,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [CW-1:0]    ae_off,
  input  logic [CW-1:0]    af_off,
  output logic             space_ok,
  output logic             data_ok,
  output logic             ae_n,
  output logic             af_n
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic             rs1, rs2;
  logic [1:0]       up;
  logic             mode_std;
  logic [CW-1:0]    ram_cnt;
  logic [AW-1:0]    wptr, rptr;
  logic             ovld;
  logic [CW-1:0]    level, free;
  logic             ready, wr_acc, rd_acc, pop;

  assign ready    = (up == 2'd2);
  assign level    = ram_cnt + CW'(ovld & ~mode_std);
  assign free     = CW'(DEPTH) - level;
  assign space_ok = ready && (level < CW'(DEPTH));
  assign data_ok  = mode_std ? (ram_cnt != '0) : ovld;
  assign wr_acc   = wr_en & space_ok;
  assign rd_acc   = rd_en & data_ok;
  assign pop      = mode_std ? rd_acc : ((~ovld | rd_acc) & (ram_cnt != '0));
  assign ae_n     = rs2 & (level > ae_off);
  assign af_n     = ~rs2 | (free > af_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up       <= 2'd0;
      mode_std <= 1'b1;
    end else if (rs2 && up != 2'd2) begin
      up <= up + 2'd1;
      if (up == 2'd0) mode_std <= mode_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      ram_cnt <= '0;
      ovld    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_acc) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop) begin
        rptr    <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
        rd_data <= mem[rptr];
      end
      ram_cnt <= ram_cnt + CW'(wr_acc) - CW'(pop);
      if (!mode_std) begin
        if (rd_acc) ovld <= 1'b0;
        if (pop)    ovld <= 1'b1;
      end
    end
  end

  p_reset_flags_r5: assert property (@(posedge clk)
    !rs2 |-> (!space_ok && !data_ok && !ae_n && af_n));

  p_ready_late_r6: assert property (@(posedge clk) disable iff (!rs2)
    $rose(space_ok) |-> $past(rs2, 2));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rs2)
    (up == 2'd2) |=> $stable(mode_std));

  p_std_hold_r3: assert property (@(posedge clk) disable iff (!rs2)
    (mode_std && !rd_acc) |=> $stable(rd_data));

  p_fwft_fall_r4: assert property (@(posedge clk) disable iff (!rs2)
    (!mode_std && !ovld && ram_cnt != '0) |=> ovld);

  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rs2)
    (wr_en && !space_ok) |=> $stable(wptr));

  p_rd_ignored_r9: assert property (@(posedge clk) disable iff (!rs2)
    (mode_std && rd_en && !data_ok) |=> ($stable(rptr) && $stable(rd_data)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rs2)
    level <= CW'(DEPTH));

endmodule

// File: tb/tb_dual_mode_fifo.sv
`timescale 1ns/1ps
module tb_dual_mode_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 36;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic [CW-1:0] ae_off = CW'(2), af_off = CW'(2);
  logic space_ok, data_ok, ae_n, af_n;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_mode_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .ae_off(ae_off),
    .af_off(af_off), .space_ok(space_ok), .data_ok(data_ok), .ae_n(ae_n), .af_n(af_n));

  // reference model
  int e;
  bit m_std;
  bit ov;
  logic [WIDTH-1:0] od;
  logic [WIDTH-1:0] q[$];

  function automatic int mlvl();
    return q.size() + ((!m_std && ov) ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int lvl;
    bit sp, dok, wa, ra, load;
    if (!rst_n) begin
      e = 0; m_std = 1; ov = 0; od = '0; q.delete();
    end else begin
      lvl = mlvl();
      sp  = (e >= 4) && (lvl < DEPTH);
      dok = m_std ? (q.size() > 0) : ov;
      wa  = wr_en && sp;
      ra  = rd_en && dok;
      if (e == 2) m_std = mode_sel;
      if (m_std) begin
        if (ra) od = q.pop_front();
      end else begin
        load = (!ov || ra) && (q.size() > 0);
        if (ra) ov = 0;
        if (load) begin od = q.pop_front(); ov = 1; end
      end
      if (wa) q.push_back(wr_data);
      if (e < 4) e++;
    end
  end

  task automatic chk(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int lvl;
    bit live;
    if (!finished) begin
      lvl  = mlvl();
      live = (e >= 2);
      chk(live ? "R6/R10 space_ok" : "R5 space_ok", WIDTH'(space_ok),
          WIDTH'((e >= 4) && (lvl < DEPTH)));
      chk(live ? "R3/R4 data_ok" : "R5 data_ok", WIDTH'(data_ok),
          WIDTH'(m_std ? (q.size() > 0) : ov));
      chk("R3/R4/R9/R10 rd_data", rd_data, od);
      chk(live ? "R7 ae_n" : "R5 ae_n", WIDTH'(ae_n), WIDTH'(live && (lvl > int'(ae_off))));
      chk(live ? "R8 af_n" : "R5 af_n", WIDTH'(af_n), WIDTH'(!live || ((DEPTH - lvl) > int'(af_off))));
    end
  end

  task automatic cyc(input bit w, input logic [WIDTH-1:0] d, input bit r);
    @(negedge clk); #1;
    wr_en = w; wr_data = d; rd_en = r;
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk); #1;
    rst_n = 0; wr_en = 0; rd_en = 0; mode_sel = m;
    repeat (5) @(negedge clk);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R6 space_ok low after third edge", WIDTH'(space_ok), '0);
    @(negedge clk);
    chk("R6 space_ok high after fourth edge", WIDTH'(space_ok), WIDTH'(1));
  endtask

  task automatic rand_traffic(input int n, input bit flip_mode);
    for (int i = 0; i < n; i++) begin
      if (i % 50 == 0) begin
        @(negedge clk); #1;
        ae_off = CW'($urandom_range(0, DEPTH));
        af_off = CW'($urandom_range(0, DEPTH));
      end
      if (flip_mode) mode_sel = $urandom_range(0, 1);
      cyc(($urandom_range(0, 9) < 6), {$urandom, 4'($urandom)}, ($urandom_range(0, 9) < 5));
    end
  endtask

  task automatic fill_and_drain();
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, WIDTH'(36'h100 + i), 0);
    cyc(0, '0, 0);
    cyc(0, '0, 0);
    chk("R10 space_ok low when full", WIDTH'(space_ok), '0);
    for (int i = 0; i < 6; i++) cyc(1, WIDTH'(36'h900 + i), 1);
    for (int i = 0; i < DEPTH + 4; i++) cyc(0, '0, 1);
    cyc(0, '0, 0);
    cyc(0, '0, 1);
    cyc(0, '0, 0);
    chk("R9 read on empty ignored", WIDTH'(data_ok), '0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    chk("R5 reset data_ok", WIDTH'(data_ok), '0);
    do_reset(1'b1);
    cyc(1, 36'hA5, 0);
    cyc(0, '0, 0);
    cyc(0, '0, 0);
    chk("R1 R3 standard: first word waits for read", rd_data, '0);
    chk("R3 not-empty flag", WIDTH'(data_ok), WIDTH'(1));
    cyc(0, '0, 1);
    cyc(0, '0, 0);
    chk("R3 read delivers first word", rd_data, 36'hA5);
    rand_traffic(400, 0);
    fill_and_drain();

    do_reset(1'b0);
    cyc(1, 36'h1234, 0);
    mode_sel = 1;
    cyc(0, '0, 0);
    cyc(0, '0, 0);
    chk("R1 R4 fall-through word shown without read", rd_data, 36'h1234);
    chk("R4 output valid", WIDTH'(data_ok), WIDTH'(1));
    cyc(0, '0, 1);
    cyc(1, 36'h5678, 0);
    cyc(0, '0, 0);
    cyc(0, '0, 0);
    chk("R2 mode held after input change", rd_data, 36'h5678);
    rand_traffic(400, 1);
    fill_and_drain();

    do_reset(1'b0);
    rand_traffic(300, 1);
    do_reset(1'b1);
    rand_traffic(200, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule